// File: doc/BRIEF.md
# Double-Buffered Instruction Prefetch Unit

This block is the instruction-fetch front end of a byte-coded processor whose instruction fetches and data loads/stores go through one memory port. It keeps two 32-bit word buffers. The execution side drains bytes one at a time from the current buffer while the other buffer is loaded from memory. When the last byte of the current buffer is taken, the roles of the two buffers swap and the emptied one is queued for the next sequential word.

Every memory access occupies the port for a fixed number of cycles. The unit decides which pending access gets the port next. In normal running, a data access from the execution side wins over an instruction prefetch. A jump discards both buffers. Any access already on the port is allowed to finish. The unit then fetches the word that holds the target, and starts a refill of the following word on the same edge that the target word arrives. Data requests wait until that refill has completed.

Top module: `ifetch_dbuf`

## Requirements
- R1: While reset is high, `byte_valid`, `mem_valid` and `d_done` are low. The first access after reset is an instruction fetch at the `RESET_VEC` parameter address, and it starts on the first clock edge after reset is released.
- R2: Every memory access holds `mem_valid` high for exactly `MEM_LAT` cycles (default 5), with `mem_addr`, `mem_write` and `mem_wdata` stable throughout. A new access may start on the edge that ends the previous one. Only one access is on the port at a time.
- R3: When nothing is consumed after reset, exactly two instruction fetches take place (`RESET_VEC` and `RESET_VEC+4`), and then the port goes idle.
- R4: Bytes are presented in increasing address order. Byte k of a fetched word is `mem_rdata[8k+7:8k]` (little endian). Taking the last byte of a buffer swaps the buffers and queues a fetch of the next sequential word. All instruction fetch addresses are word aligned.
- R5: `byte_valid` is high only while the current buffer holds unconsumed bytes. After reset it first rises on the edge that completes the first fetch.
- R6: When a data request and an instruction prefetch are both ready to start in the same cycle during normal running, the data access is started first. The prefetch starts on the edge that ends the data access.
- R7: A data access drives `mem_write`, `mem_addr` and `mem_wdata` from the request. `d_done` is high only in the last cycle of that access, and in that cycle `d_rdata` carries the memory read data.
- R8: A `jump` empties both buffers, and `byte_valid` stays low until the target word arrives. An access already on the port finishes first. The fetch of the target's word starts on the edge that ends that access, and the result of a discarded instruction fetch is dropped.
- R9: The refill fetch of the word after the target starts on the same edge that the target word is captured.
- R10: For a target that is not word aligned, the first byte presented is the byte at the target address. The lower bytes of that word are skipped.
- R11: A data request is not started between a jump and the completion of the refill fetch. With buffers full after the refill, it starts one cycle after the refill ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | output | 1 | Current buffer holds an unconsumed byte |
| byte_out | output | 8 | Next instruction byte |
| byte_take | input | 1 | Execution consumes `byte_out` this cycle |
| jump | input | 1 | One-cycle jump request |
| jump_addr | input | ADDR_W | Jump target byte address |
| d_req | input | 1 | Data access request, held until `d_done` |
| d_write | input | 1 | 1 = store, 0 = load |
| d_addr | input | ADDR_W | Data address |
| d_wdata | input | 32 | Store data |
| d_done | output | 1 | Last cycle of the granted data access |
| d_rdata | output | 32 | Load data, valid with `d_done` |
| mem_valid | output | 1 | Memory access in progress |
| mem_write | output | 1 | Current access is a write |
| mem_addr | output | ADDR_W | Current access address |
| mem_wdata | output | 32 | Current write data |
| mem_rdata | input | 32 | Memory read data, sampled in the last access cycle |

## Verification
Two collisions matter in this block. The first is a data request and a prefetch arriving in the same cycle. The bench provokes it by taking the last byte of a buffer and raising a load request at the same clock. It then judges the result by checking that the first new access carries the data address, and that the sequential word follows on the edge that ends the load. The second is a jump landing on top of an access already in flight, at the same time as a data request. Here the bench checks the order of accesses on the port (stale word, target, refill, then data) and the exact cycle in which `d_done` appears.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_JWAIT   = 2'd1,
    PH_JTGT    = 2'd2,
    PH_JREFILL = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_INSN = 2'd1,
    OWN_DATA = 2'd2
  } owner_t;

  // Byte lane k of a little-endian word.
  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] k);
    return w[{k, 3'b000} +: 8];
  endfunction

  // Empty buffer slots after this edge, counting a completing fill and a swap.
  function automatic int free_slots(input logic f0, input logic f1,
                                    input logic fill_now, input logic swap_now);
    return 2 - int'(f0) - int'(f1) - int'(fill_now) + int'(swap_now);
  endfunction

endpackage

// File: rtl/ifetch_bus_timer.sv
module ifetch_bus_timer #(
  parameter int LAT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt;

  assign last = busy && (cnt == CW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/ifetch_word_buf.sv
module ifetch_word_buf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic              full,
  output logic [WORD_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      dout <= '0;
    end else if (clear) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
      dout <= din;
    end
  end
endmodule

// File: rtl/ifetch_dbuf.sv
module ifetch_dbuf
  import ifetch_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                MEM_LAT   = 5,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h100
) (
  input  logic              clk,
  input  logic              rst,
  output logic              byte_valid,
  output logic [7:0]        byte_out,
  input  logic              byte_take,
  input  logic              jump,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic              d_req,
  input  logic              d_write,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [31:0]       d_wdata,
  output logic              d_done,
  output logic [31:0]       d_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int NBUF       = 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  phase_t            phase;
  owner_t            owner;
  logic              cs;
  logic [1:0]        ptr;
  logic [ADDR_W-1:0] fa;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] tgt_word;

  logic              bus_busy, bus_last, bus_free;
  logic              acc_start, d_grant, if_grant;
  logic [ADDR_W-1:0] issue_addr;
  logic              done_insn, fill_now, tgt_done, take_ok, swap_now, cur_full;
  logic              fill_idx;
  logic [NBUF-1:0]   buf_full, buf_clr, buf_ld;
  logic [WORD_W-1:0] buf_data [NBUF];

  ifetch_bus_timer #(.LAT(MEM_LAT)) u_timer (
    .clk(clk), .rst(rst), .start(acc_start), .busy(bus_busy), .last(bus_last)
  );

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
    ifetch_word_buf #(.WORD_W(WORD_W)) u_buf (
      .clk(clk), .rst(rst), .clear(buf_clr[gi]), .load(buf_ld[gi]),
      .din(mem_rdata), .full(buf_full[gi]), .dout(buf_data[gi])
    );
  end

  assign tgt_word   = {tgt[ADDR_W-1:2], 2'b00};
  assign bus_free   = !bus_busy || bus_last;
  assign done_insn  = bus_last && (owner == OWN_INSN);
  assign d_done     = bus_last && (owner == OWN_DATA);
  assign d_rdata    = mem_rdata;
  assign mem_valid  = bus_busy;

  assign cur_full   = buf_full[cs];
  assign byte_valid = cur_full;
  assign byte_out   = pick_byte(buf_data[cs], ptr);
  assign take_ok    = byte_take && byte_valid && !jump;
  assign swap_now   = take_ok && (ptr == 2'd3);
  assign fill_now   = done_insn && (phase != PH_JWAIT) && !jump;
  assign fill_idx   = cur_full ? ~cs : cs;
  assign tgt_done   = done_insn && (phase == PH_JTGT) && !jump;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      buf_clr[i] = jump || (swap_now && (cs == 1'(i)));
      buf_ld[i]  = fill_now && (fill_idx == 1'(i));
    end
  end

  // Port arbitration: one access at a time, data first while running.
  always_comb begin
    d_grant    = 1'b0;
    if_grant   = 1'b0;
    issue_addr = fa;
    if (!jump && bus_free) begin
      unique case (phase)
        PH_RUN: begin
          if (d_req && !d_done) begin
            d_grant    = 1'b1;
            issue_addr = d_addr;
          end else if (free_slots(buf_full[0], buf_full[1], fill_now, swap_now) > 0) begin
            if_grant   = 1'b1;
          end
        end
        PH_JWAIT: begin
          if_grant   = 1'b1;
          issue_addr = tgt_word;
        end
        PH_JTGT: begin
          if (tgt_done) begin
            if_grant   = 1'b1;
            issue_addr = tgt_word + STEP;
          end
        end
        default: ;
      endcase
    end
  end

  assign acc_start = d_grant || if_grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_RUN;
      owner     <= OWN_NONE;
      cs        <= 1'b0;
      ptr       <= 2'd0;
      fa        <= RESET_VEC;
      tgt       <= '0;
      mem_addr  <= '0;
      mem_write <= 1'b0;
      mem_wdata <= '0;
    end else begin
      if (acc_start) begin
        owner     <= d_grant ? OWN_DATA : OWN_INSN;
        mem_addr  <= issue_addr;
        mem_write <= d_grant && d_write;
        mem_wdata <= d_wdata;
      end else if (bus_last) begin
        owner     <= OWN_NONE;
      end

      if (jump) begin
        phase <= PH_JWAIT;
        tgt   <= jump_addr;
        ptr   <= 2'd0;
      end else begin
        unique case (phase)
          PH_RUN:     if (if_grant) fa <= fa + STEP;
          PH_JWAIT:   if (if_grant) phase <= PH_JTGT;
          PH_JTGT:    if (tgt_done) phase <= PH_JREFILL;
          PH_JREFILL: if (done_insn) begin
            phase <= PH_RUN;
            fa    <= tgt_word + STEP + STEP;
          end
          default: ;
        endcase

        if (swap_now) begin
          cs  <= ~cs;
          ptr <= 2'd0;
        end else if (fill_now && !cur_full) begin
          ptr <= (phase == PH_JTGT) ? tgt[1:0] : 2'd0;
        end else if (take_ok) begin
          ptr <= ptr + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ifetch_dbuf_chk.sv
module ifetch_dbuf_chk
  import ifetch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_valid,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              d_req,
  input logic              d_done,
  input logic              jump,
  input phase_t            phase,
  input logic              acc_start,
  input logic              bus_free,
  input logic              bus_last,
  input logic              d_grant,
  input logic              if_grant,
  input logic              tgt_done
);
  p_start_free_r2: assert property (@(posedge clk) disable iff (rst)
    acc_start |-> bus_free);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !bus_last) |=> (mem_valid && $stable(mem_addr)));

  p_aligned_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    if_grant |=> (mem_addr[1:0] == 2'b00));

  p_one_owner_r6: assert property (@(posedge clk) disable iff (rst)
    !(d_grant && if_grant));

  p_data_first_r6: assert property (@(posedge clk) disable iff (rst)
    (d_req && !d_done && bus_free && !jump && phase == PH_RUN) |-> d_grant);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    d_done |=> !d_done);

  p_hidden_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_JWAIT || phase == PH_JTGT) |-> !byte_valid);

  p_refill_now_r9: assert property (@(posedge clk) disable iff (rst)
    tgt_done |-> if_grant);

  p_data_held_r11: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_RUN) |-> !d_grant);
endmodule

bind ifetch_dbuf ifetch_dbuf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .mem_valid(mem_valid),
  .mem_addr(mem_addr), .d_req(d_req), .d_done(d_done), .jump(jump),
  .phase(phase), .acc_start(acc_start), .bus_free(bus_free),
  .bus_last(bus_last), .d_grant(d_grant), .if_grant(if_grant),
  .tgt_done(tgt_done)
);

// File: tb/test_ifetch_dbuf.sv
`timescale 1ns/100ps
module test_ifetch_dbuf;
  localparam int AW  = 16;
  localparam int LAT = 5;
  localparam logic [AW-1:0] RV = 16'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_valid, byte_take = 1'b0, jump = 1'b0;
  logic [7:0] byte_out;
  logic [AW-1:0] jump_addr = '0, d_addr = '0, mem_addr;
  logic d_req = 1'b0, d_write = 1'b0, d_done, mem_valid, mem_write;
  logic [31:0] d_wdata = '0, d_rdata, mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  int n_acc = 0, acc_cyc = 0, busy_cyc = 0, stab_err = 0;
  logic [AW-1:0] log_addr [64];
  logic [AW-1:0] a0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] bytef(input logic [AW-1:0] b);
    return b[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] memword(input logic [AW-1:0] a);
    logic [31:0] w;
    logic [AW-1:0] base;
    base = {a[AW-1:2], 2'b00};
    for (int k = 0; k < 4; k++) w[k*8 +: 8] = bytef(base + AW'(k));
    return w;
  endfunction

  assign mem_rdata = memword(mem_addr);

  ifetch_dbuf #(.ADDR_W(AW), .MEM_LAT(LAT), .RESET_VEC(RV)) i_ifetch_dbuf (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_out(byte_out),
    .byte_take(byte_take), .jump(jump), .jump_addr(jump_addr),
    .d_req(d_req), .d_write(d_write), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_done(d_done), .d_rdata(d_rdata), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Port monitor: splits mem_valid into LAT-cycle accesses and logs them.
  always @(negedge clk) begin
    if (rst) acc_cyc = 0;
    else if (mem_valid) begin
      if (acc_cyc == 0) begin
        if (n_acc < 64) log_addr[n_acc] = mem_addr;
        n_acc = n_acc + 1;
        a0 = mem_addr;
      end else if (mem_addr != a0) stab_err = stab_err + 1;
      acc_cyc = (acc_cyc + 1) % LAT;
      busy_cyc = busy_cyc + 1;
    end else acc_cyc = 0;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; byte_take = 0; jump = 0; d_req = 0; d_write = 0;
    repeat (3) @(negedge clk);
    n_acc = 0; busy_cyc = 0;
    rst = 1'b0;
  endtask

  task automatic consume(input int n, input logic [AW-1:0] start);
    int got = 0, guard = 0;
    logic [AW-1:0] a = start;
    while (got < n && guard < 400) begin
      @(negedge clk);
      guard++;
      if (byte_valid) begin
        check(byte_out == bytef(a), "R4 byte order", 32'(byte_out), 32'(bytef(a)));
        byte_take = 1'b1;
        a = a + 1'b1;
        got++;
      end else byte_take = 1'b0;
    end
    check(got == n, "R4 bytes delivered", got, n);
    @(negedge clk);
    byte_take = 1'b0;
  endtask

  task automatic t_reset_fill();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!byte_valid && !mem_valid && !d_done, "R1 reset outputs",
          {byte_valid, mem_valid, d_done}, 0);
    n_acc = 0; busy_cyc = 0;
    rst = 1'b0;
    @(negedge clk);
    check(mem_valid && mem_addr == RV, "R1 first fetch", mem_addr, RV);
    repeat (LAT - 1) @(negedge clk);
    check(!byte_valid, "R5 no byte before fill", byte_valid, 0);
    @(negedge clk);
    check(byte_valid && byte_out == bytef(RV), "R5 byte after fill", byte_out, bytef(RV));
    repeat (3 * LAT) @(negedge clk);
    check(busy_cyc == 2 * LAT, "R3 two fetches then idle", busy_cyc, 2 * LAT);
    check(n_acc == 2 && log_addr[1] == RV + 4, "R3 second word", log_addr[1], RV + 4);
  endtask

  task automatic t_stream();
    do_reset();
    repeat (3 * LAT) @(negedge clk);
    consume(12, RV);
    repeat (3 * LAT) @(negedge clk);
    check(log_addr[2] == RV + 8 && log_addr[3] == RV + 12, "R4 sequential refetch",
          log_addr[3], RV + 12);
  endtask

  task automatic t_data_first();
    int k;
    do_reset();
    repeat (3 * LAT) @(negedge clk);
    consume(3, RV);
    byte_take = 1'b1; d_req = 1'b1; d_write = 1'b0; d_addr = 16'h0200;
    @(negedge clk);
    byte_take = 1'b0;
    check(mem_valid && mem_addr == 16'h0200 && !mem_write, "R6 data wins", mem_addr, 16'h0200);
    k = 0;
    while (!d_done && k < 4 * LAT) begin @(negedge clk); k++; end
    check(d_done && d_rdata == memword(16'h0200), "R7 read data", d_rdata, memword(16'h0200));
    d_req = 1'b0;
    @(negedge clk);
    check(mem_valid && mem_addr == RV + 8, "R6 prefetch follows", mem_addr, RV + 8);
  endtask

  task automatic t_data_write();
    int k;
    int seen = 0;
    do_reset();
    repeat (3 * LAT) @(negedge clk);
    d_req = 1'b1; d_write = 1'b1; d_addr = 16'h0210; d_wdata = 32'hCAFE_F00D;
    for (k = 1; k <= LAT + 2; k++) begin
      @(negedge clk);
      if (k == 1)
        check(mem_valid && mem_write && mem_addr == 16'h0210 && mem_wdata == 32'hCAFE_F00D,
              "R7 write fields", mem_wdata, 32'hCAFE_F00D);
      if (d_done && seen == 0) begin seen = k; d_req = 1'b0; end
    end
    check(seen == LAT, "R7 done in last cycle", seen, LAT);
  endtask

  task automatic t_jump();
    do_reset();
    @(negedge clk);
    jump = 1'b1; jump_addr = 16'h0143;
    @(negedge clk);
    jump = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check(!byte_valid, "R8 stale word dropped", byte_valid, 0);
    check(mem_valid && mem_addr == 16'h0140, "R8 target after in-flight", mem_addr, 16'h0140);
    repeat (LAT) @(negedge clk);
    check(byte_valid && byte_out == bytef(16'h0143), "R10 unaligned first byte",
          byte_out, bytef(16'h0143));
    check(mem_valid && mem_addr == 16'h0144, "R9 refill immediate", mem_addr, 16'h0144);
    consume(9, 16'h0143);
    repeat (3 * LAT) @(negedge clk);
    check(log_addr[0] == RV && log_addr[1] == 16'h0140 && log_addr[3] == 16'h0148,
          "R8 access order", log_addr[3], 16'h0148);
  endtask

  task automatic t_hold();
    int k = 1;
    do_reset();
    @(negedge clk);
    jump = 1'b1; jump_addr = 16'h0180;
    d_req = 1'b1; d_write = 1'b0; d_addr = 16'h0220;
    while (!d_done && k < 8 * LAT) begin
      @(negedge clk);
      jump = 1'b0;
      k++;
    end
    check(k == 4 * LAT + 1, "R11 data after refill", k, 4 * LAT + 1);
    check(d_rdata == memword(16'h0220), "R11 read data", d_rdata, memword(16'h0220));
    d_req = 1'b0;
    repeat (2) @(negedge clk);
    check(log_addr[1] == 16'h0180 && log_addr[2] == 16'h0184 && log_addr[3] == 16'h0220,
          "R11 access order", log_addr[3], 16'h0220);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_fill();
    t_stream();
    t_data_first();
    t_data_write();
    t_jump();
    t_hold();
    check(stab_err == 0, "R2 stable access", stab_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule